// File: doc/BRIEF.md
# Reset and Startup Sequencer

This block turns two reset sources into the internal reset of a converter's digital logic: a power-good indication and an active-low external reset input. Either source can assert the internal reset at any moment without waiting for a clock edge. Release always happens in step with the system clock, and it comes in two stages.

The first stage holds the logic in reset for a fixed number of system clock cycles. It only begins counting once the clock has shown it is running. The second stage lets the filter logic run while the output is still forced to zero. It waits a long run of sample periods, counted on a sample-rate tick, so that the decimation filter can settle. After that the data is flagged as valid. Either reset source can restart the whole sequence at any point.

Top module: `rst_seq`

## Requirements
- R1: `core_rst` is 1 while `pwr_good` is 0 or `ext_rst_n` is 0. The assertion is asynchronous: a low pulse on `ext_rst_n` shorter than one clock period, falling between clock edges, sets `core_rst` before the next rising edge.
- R2: A rising `ext_rst_n` passes through a two-flop synchronizer. If `pwr_good` is already high and the clock is qualified, `core_rst` falls on the 1026th rising edge after the release: 2 synchronizer edges plus HOLD_CYCLES = 1024.
- R3: While `core_rst` is 1, `force_zero` is 1 and `data_ok` is 0. At every clock edge, `force_zero` is the inverse of `data_ok`.
- R4: If either source reasserts reset during the hold count, the count starts over. `core_rst` then falls 1026 edges after the later release, and never earlier.
- R5: The hold count starts only after PRE_CLKS = 3 clock edges have been seen with `pwr_good` high. When `pwr_good` rises last, `core_rst` falls on the 1027th edge after it rises. With no clock, `core_rst` stays 1.
- R6: The settling count advances only on rising edges where `fs_tick` is 1 and `core_rst` was already 0 before that edge. Ticks seen during reset or the hold stage are ignored.
- R7: `data_ok` rises on the edge that samples the SETTLE_TICKS-th counted tick (default 18436). It stays 1 until reset is reasserted.
- R8: Reasserting reset during settling, or after `data_ok` has risen, clears `data_ok` at once. Both stages then run again in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_good | input | 1 | Supply-good indication, 1 = supply valid |
| ext_rst_n | input | 1 | External reset, active low |
| fs_tick | input | 1 | One-cycle pulse per sample period |
| core_rst | output | 1 | Internal reset for filter and logic, active high |
| force_zero | output | 1 | 1 while output data must be forced to zero |
| data_ok | output | 1 | 1 once the filter has settled and data is valid |

## Verification
The bench applies a sub-period reset pulse that falls between clock edges. A design with synchronous assertion would miss it and keep `data_ok` high. It aborts a hold count halfway through, which catches a counter that resumes instead of restarting because `core_rst` would fall too early. It releases through `pwr_good` with the clock stopped and then started, so a design without clock qualification releases one edge early or with no clock at all. It also drives ticks throughout reset and at periods of 1, 2 and 3 cycles. A settling counter that runs on every clock, or that counts ticks before release, would raise `data_ok` on the wrong edge.

// File: rtl/rstseq_pkg.sv
`timescale 1ns/1ps
package rstseq_pkg;
  // Counter width able to hold values 0..n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rstseq_sync.sv
`timescale 1ns/1ps
// Asynchronous-assert, synchronous-release reset synchronizer.
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rel
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh <= '0;
    else         sh <= {sh[STAGES-2:0], 1'b1};
  end

  assign rel = sh[STAGES-1];
endmodule

// File: rtl/rstseq_clkcheck.sv
`timescale 1ns/1ps
// Qualifies the clock: counts edges seen while power is good.
module rstseq_clkcheck #(
  parameter int PRE_CLKS = 3
) (
  input  logic clk,
  input  logic pg,
  output logic clk_ok
);
  import rstseq_pkg::*;
  localparam int W = cnt_width(PRE_CLKS);
  localparam logic [W-1:0] FULL = W'(PRE_CLKS);

  logic [W-1:0] seen;

  always_ff @(posedge clk or negedge pg) begin
    if (!pg)              seen <= '0;
    else if (seen != FULL) seen <= seen + 1'b1;
  end

  assign clk_ok = (seen == FULL);
endmodule

// File: rtl/rstseq_timer.sv
`timescale 1ns/1ps
// Sticky done flag after LIMIT qualified steps while run is high.
module rstseq_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic arst_n,
  input  logic run,
  input  logic step,
  output logic done
);
  import rstseq_pkg::*;
  localparam int W = cnt_width(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (step && !done) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) done <= 1'b1;
    end
  end

  // R8: a finished stage always implies its enabling stage is active
  assert_done_needs_run_R8: assert property (@(posedge clk) disable iff (!arst_n)
    done |-> run);
  // R7: the step counter never runs past its limit
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!arst_n)
    cnt <= W'(LIMIT));
endmodule

// File: rtl/rst_seq.sv
`timescale 1ns/1ps
module rst_seq #(
  parameter int SYNC_STAGES  = 2,
  parameter int PRE_CLKS     = 3,
  parameter int HOLD_CYCLES  = 1024,
  parameter int SETTLE_TICKS = 18436
) (
  input  logic clk,
  input  logic pwr_good,
  input  logic ext_rst_n,
  input  logic fs_tick,
  output logic core_rst,
  output logic force_zero,
  output logic data_ok
);
  logic raw_n;
  logic rel;
  logic clk_ok;
  logic hold_done;
  logic settle_done;

  assign raw_n = pwr_good & ext_rst_n;

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(raw_n), .rel(rel)
  );

  rstseq_clkcheck #(.PRE_CLKS(PRE_CLKS)) u_clkchk (
    .clk(clk), .pg(pwr_good), .clk_ok(clk_ok)
  );

  // Stage 1: fixed count of qualified system clocks.
  rstseq_timer #(.LIMIT(HOLD_CYCLES)) u_hold (
    .clk(clk), .arst_n(raw_n), .run(rel), .step(clk_ok), .done(hold_done)
  );

  // Stage 2: settling count in sample periods.
  rstseq_timer #(.LIMIT(SETTLE_TICKS)) u_settle (
    .clk(clk), .arst_n(raw_n), .run(hold_done), .step(fs_tick), .done(settle_done)
  );

  assign core_rst   = ~hold_done;
  assign data_ok    = settle_done;
  assign force_zero = ~settle_done;

  // R3: no valid data while the logic is held in reset
  assert_quiet_in_reset_R3: assert property (@(posedge clk) disable iff (!raw_n)
    core_rst |-> !data_ok);
  // R7: valid rises only on an edge that sampled a tick
  assert_valid_on_tick_R7: assert property (@(posedge clk) disable iff (!raw_n)
    $rose(data_ok) |-> $past(fs_tick));
  // R5: release requires a qualified clock and a synchronized release
  assert_release_gated_R5: assert property (@(posedge clk) disable iff (!raw_n)
    $fell(core_rst) |-> ($past(clk_ok) && $past(rel)));
endmodule

// File: tb/rst_seq_test.sv
`timescale 1ns/1ps
module rst_seq_test;
  localparam int HOLD   = 1024;
  localparam int SETTLE = 18436;

  logic clk = 1'b0;
  logic clk_en = 1'b0;
  logic pwr_good = 1'b1;
  logic ext_rst_n = 1'b0;
  logic fs_tick = 1'b0;
  logic core_rst, force_zero, data_ok;

  int total = 0;
  int bad = 0;
  int prints = 0;
  int unsigned ecount = 0;
  int tcnt = 0;
  int tick_per = 1;
  int tph = 0;
  logic prev_rst = 1'b1;
  logic prev_exp = 1'b0;
  logic finished = 1'b0;

  typedef struct { int unsigned at; string tag; } exp_t;
  exp_t q[$];

  rst_seq uut (
    .clk(clk), .pwr_good(pwr_good), .ext_rst_n(ext_rst_n), .fs_tick(fs_tick),
    .core_rst(core_rst), .force_zero(force_zero), .data_ok(data_ok)
  );

  always #5 if (clk_en) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      if (prints < 20)
        $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      prints++;
    end
  endtask

  // Tick generator, driven away from the active edge.
  always @(negedge clk) begin
    fs_tick <= (tph == 0);
    tph <= (tph + 1) % tick_per;
  end

  always @(posedge clk) begin
    ecount++;
    if (!prev_rst && fs_tick) tcnt++;
  end

  // Monitor: pops expected release edges, tracks valid against counted ticks.
  always @(negedge clk) begin
    logic expv;
    if (q.size() != 0 && ecount == q[0].at) begin
      check(!core_rst && prev_rst, q[0].tag, "core_rst fall edge", core_rst, 0);
      void'(q.pop_front());
    end else if (prev_rst && !core_rst) begin
      check(1'b0, "R4", "unexpected core_rst release", ecount, 0);
    end
    if (core_rst) tcnt = 0;
    expv = !core_rst && (tcnt >= SETTLE);
    if (data_ok !== expv) check(1'b0, "R7", "data_ok vs counted ticks (R6)", data_ok, expv);
    else if (expv && !prev_exp) check(1'b1, "R7", "data_ok rise", data_ok, 1);
    if (force_zero !== !data_ok) check(1'b0, "R3", "force_zero inverse", force_zero, !data_ok);
    prev_exp = expv;
    prev_rst = core_rst;
  end

  task automatic expect_release(input int unsigned n, input string tag);
    q.delete();
    q.push_back('{at: ecount + n, tag: tag});
  endtask

  task automatic wait_valid();
    while (!data_ok) @(negedge clk);
    repeat (3) @(negedge clk);
    check(data_ok === 1'b1, "R7", "data_ok held", data_ok, 1);
    check(q.size() == 0, "R2", "pending release edges", q.size(), 0);
  endtask

  // Short asynchronous pulse on ext_rst_n, then release.
  task automatic short_pulse(input string tag);
    @(negedge clk);
    #1 ext_rst_n = 1'b0;
    #1;
    check(core_rst === 1'b1, "R1", {"async core_rst ", tag}, core_rst, 1);
    check(data_ok === 1'b0 && force_zero === 1'b1, "R8", {"async clear ", tag}, data_ok, 0);
    #1 ext_rst_n = 1'b1;
    expect_release(HOLD + 2, tag);
  endtask

  initial begin
    // Reset state with no clock: make a real falling edge on power-good.
    #1 pwr_good = 1'b1; ext_rst_n = 1'b1;
    #1 pwr_good = 1'b0; ext_rst_n = 1'b0;
    #10;
    check(core_rst === 1'b1, "R1", "reset state core_rst", core_rst, 1);
    check(force_zero === 1'b1, "R3", "reset state force_zero", force_zero, 1);
    check(data_ok === 1'b0, "R3", "reset state data_ok", data_ok, 0);

    // Sources released but clock stopped: no release may happen.
    ext_rst_n = 1'b1;
    pwr_good = 1'b1;
    #200;
    check(core_rst === 1'b1, "R5", "no release without clock", core_rst, 1);

    // Start clock: three qualifying edges, then the hold count.
    expect_release(HOLD + 3, "R5");
    clk_en = 1'b1;
    tick_per = 1;
    wait_valid();

    // Pulse during valid data, abort the hold count, then settle with period 3.
    tick_per = 3;
    short_pulse("R8");
    repeat (500) @(negedge clk);
    check(core_rst === 1'b1, "R4", "still held mid count", core_rst, 1);
    short_pulse("R4");
    wait_valid();

    // Power-good drop mid settling, release through power-good, period 2.
    tick_per = 2;
    short_pulse("R2");
    while (core_rst) @(negedge clk);
    repeat (5000) @(negedge clk);
    check(data_ok === 1'b0, "R6", "not valid mid settling", data_ok, 0);
    #1 pwr_good = 1'b0;
    #1;
    check(core_rst === 1'b1, "R1", "pwr_good drop core_rst", core_rst, 1);
    repeat (3) @(negedge clk);
    #1 pwr_good = 1'b1;
    expect_release(HOLD + 3, "R5");
    wait_valid();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1800000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", ecount, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule